// File: doc/BRIEF.md
# Statically Scheduled Pipelined Execution Core

This block is a single-issue fixed-point execution core whose timing is settled entirely when the program is built. A program counter advances by one every clock. Each instruction word then moves through five stages: fetch, decode, operand fetch, execute and write back. The core has no interlock, no forwarding and no stall. Every operator has a fixed latency, and a result lands in data memory in exactly the cycle that latency dictates. The code generator must therefore place each consumer far enough behind its producer and must avoid two results that compete for the single write port in one cycle.

Each instruction names two source addresses, a pre-operation for each source, an operation and a destination address. The pre-operations can negate, take the absolute value of, or zero an operand before it reaches the operator. A subtraction is therefore an addition whose second operand is negated. Input instructions copy an input register into data memory. Output instructions copy a memory word into an output register. A no-operation word pads the schedule. The operators are fully pipelined, so a new instruction can issue on every cycle while earlier ones are still in flight.

Top module: `sched_core`

## Requirements
- R1: After reset is released, `prog_addr` starts at 0 and rises by exactly 1 on every clock, with no stall. The instruction at slot s is the word on `prog_data` during the cycle in which `prog_addr` equals s.
- R2: The instruction word is 25 bits wide. Bits [5:0] hold source 1, bits [11:6] source 2, bits [13:12] pre-operation 1, bits [15:14] pre-operation 2, bits [18:16] the opcode and bits [24:19] the destination. Opcodes: 0 no-op, 1 input, 2 output, 3 add, 4 multiply. Codes 5 to 7 are reserved and act as no-ops.
- R3: During cycle s+2 the instruction of slot s places source 1 on `rd_addr_a` and source 2 on `rd_addr_b`. It expects the addressed words on `rd_data_a` and `rd_data_b` one cycle later.
- R4: An input instruction has latency 1. It writes input register number source 1 to the destination, with `wr_en` high in cycle s+2, so that the instruction of slot s+1 reads the new value.
- R5: An add has latency 5. It writes pre1(a)+pre2(b) modulo 2^16 in cycle s+6. An instruction at slot s+5 reads the new value, and one at slot s+4 reads the old value.
- R6: A multiply has latency 6. It treats the operands as signed Q8.8 values and writes (pre1(a)·pre2(b)) arithmetically shifted right by 8 and truncated to 16 bits, in cycle s+7.
- R7: Pre-operation codes: 0 passes the operand, 1 negates it (two's complement), 2 takes its absolute value, 3 replaces it with zero. A subtraction is an add with pre-operation 2 set to 1.
- R8: Independent instructions issued in consecutive slots all complete, each with one write in its own cycle.
- R9: No-op, reserved and output instructions never raise `wr_en`. A cycle with `wr_en` high always follows a result that was due in the previous cycle.
- R10: An output instruction at slot s loads pre1(mem[source 1]) into output register number destination. The new value is visible on `out_regs` from cycle s+4, and output register k occupies bits [16k+15:16k].
- R11: When results from two or more operators are due in the same cycle, `wr_clash` is high during that write cycle. Only one result is written, chosen by priority: multiply over add over input.
- R12: While reset is held low, `prog_addr`, `wr_en`, `wr_clash` and all output registers are zero.
- R13: The eight-instruction example schedule finishes in 12 slots. The schedule is: four inputs, two multiplies by constants, an add and a subtract. Its last result is readable by slot 12, and every result matches fixed-point arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_addr | output | 6 | Program memory read address (program counter) |
| prog_data | input | 25 | Instruction word at `prog_addr`, combinational |
| rd_addr_a | output | 6 | Data memory read address, source 1 |
| rd_addr_b | output | 6 | Data memory read address, source 2 |
| rd_data_a | input | 16 | Data read for source 1, one cycle after the address |
| rd_data_b | input | 16 | Data read for source 2, one cycle after the address |
| wr_en | output | 1 | Data memory write enable |
| wr_addr | output | 6 | Data memory write address |
| wr_data | output | 16 | Data memory write data |
| wr_clash | output | 1 | High in a write cycle in which two results were due |
| in_regs | input | 64 | Four 16-bit input registers, packed |
| out_regs | output | 64 | Four 16-bit output registers, packed |

## Verification
A wrong stage count or a mis-sized latency delay shows at the ports as a write on `wr_en` one or more cycles away from the expected cycle. Such a fault is visible within at most seven cycles of the instruction's slot. The slot-11 and slot-12 output reads of the same word also expose it, because they return the old and new values. A corrupted pre-operation or operator shows in the written data and in the output registers as soon as the write happens. A broken arbitration or clash flag shows as a missing `wr_clash` pulse, or as the losing destination being overwritten, in the very cycle of the collision.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int FRAC_W  = 8;
  localparam int OP_W    = 3;
  localparam int PRE_W   = 2;
  localparam int INSTR_W = 3 * ADDR_W + OP_W + 2 * PRE_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_IN  = 3'd1,
    OP_OUT = 3'd2,
    OP_ADD = 3'd3,
    OP_MUL = 3'd4
  } opcode_e;

  typedef enum logic [PRE_W-1:0] {
    PRE_PASS = 2'd0,
    PRE_NEG  = 2'd1,
    PRE_ABS  = 2'd2,
    PRE_ZERO = 2'd3
  } preop_e;

  // destination occupies the top bits, source 1 the bottom bits
  typedef struct packed {
    addr_t             dest;
    logic [OP_W-1:0]   op;
    logic [PRE_W-1:0]  pre2;
    logic [PRE_W-1:0]  pre1;
    addr_t             src2;
    addr_t             src1;
  } instr_t;

  typedef struct packed {
    addr_t dest;
    word_t data;
  } result_t;

  function automatic word_t pre_apply(input logic [PRE_W-1:0] sel, input word_t v);
    word_t neg;
    neg = word_t'(~v + 1'b1);
    case (sel)
      PRE_PASS: return v;
      PRE_NEG:  return neg;
      PRE_ABS:  return v[DATA_W-1] ? neg : v;
      default:  return '0;
    endcase
  endfunction

  function automatic word_t fx_add(input word_t a, input word_t b);
    return word_t'(a + b);
  endfunction

  function automatic word_t fx_mul(input word_t a, input word_t b);
    logic signed [2*DATA_W-1:0] prod;
    logic signed [2*DATA_W-1:0] scaled;
    prod   = $signed(a) * $signed(b);
    scaled = prod >>> FRAC_W;
    return scaled[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_v,
  output logic [WIDTH-1:0] out_data
);
  // DEPTH must be at least 1; each stage holds one in-flight result
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic             sv;
    logic [WIDTH-1:0] sd;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv <= 1'b0;
          sd <= '0;
        end else begin
          sv <= in_v;
          sd <= in_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv <= 1'b0;
          sd <= '0;
        end else begin
          sv <= g_stage[g-1].sv;
          sd <= g_stage[g-1].sd;
        end
      end
    end
  end

  assign out_v    = g_stage[DEPTH-1].sv;
  assign out_data = g_stage[DEPTH-1].sd;
endmodule

// File: rtl/sc_fetch_decode.sv
module sc_fetch_decode
  import sc_core_pkg::*;
#(
  parameter int PC_W = 6,
  parameter int N_IN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [PC_W-1:0]        prog_addr,
  input  logic [INSTR_W-1:0]     prog_data,
  input  logic [N_IN*DATA_W-1:0] in_regs,
  // input-instruction result, due in the decode cycle
  output logic                   in_v,
  output addr_t                  in_dest,
  output word_t                  in_data,
  // operand-fetch stage fields
  output addr_t                  of_src1,
  output addr_t                  of_src2,
  output logic [OP_W-1:0]        of_op,
  output logic [PRE_W-1:0]       of_pre1,
  output logic [PRE_W-1:0]       of_pre2,
  output addr_t                  of_dest
);
  logic [PC_W-1:0] pc_q;
  instr_t          ifid_q;
  instr_t          of_q;

  // fetch: counter never holds, the schedule is fixed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else begin
      pc_q   <= pc_q + 1'b1;
      ifid_q <= instr_t'(prog_data);
    end
  end

  assign prog_addr = pc_q;

  // decode: input instructions complete here
  always_comb begin
    in_data = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (ifid_q.src1 == ADDR_W'(k)) in_data = in_regs[k*DATA_W +: DATA_W];
    end
  end

  assign in_v    = (ifid_q.op == OP_IN);
  assign in_dest = ifid_q.dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) of_q <= '0;
    else        of_q <= ifid_q;
  end

  assign of_src1 = of_q.src1;
  assign of_src2 = of_q.src2;
  assign of_op   = of_q.op;
  assign of_pre1 = of_q.pre1;
  assign of_pre2 = of_q.pre2;
  assign of_dest = of_q.dest;

  a_r1_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prog_addr == PC_W'($past(prog_addr) + 1'b1));
endmodule

// File: rtl/sc_execute.sv
module sc_execute
  import sc_core_pkg::*;
#(
  parameter int ADD_LAT = 5,
  parameter int MUL_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   of_op,
  input  logic [PRE_W-1:0]  of_pre1,
  input  logic [PRE_W-1:0]  of_pre2,
  input  addr_t             of_dest,
  input  word_t             rd_a,
  input  word_t             rd_b,
  output logic              add_v,
  output addr_t             add_dest,
  output word_t             add_data,
  output logic              mul_v,
  output addr_t             mul_dest,
  output word_t             mul_data,
  output logic              out_we,
  output addr_t             out_idx,
  output word_t             out_data
);
  // three cycles pass before operands arrive (decode, operand fetch, read)
  localparam int ISSUE_TO_EX = 3;
  localparam int ADD_DEPTH   = ADD_LAT - ISSUE_TO_EX;
  localparam int MUL_DEPTH   = MUL_LAT - ISSUE_TO_EX;
  localparam int RES_W       = ADDR_W + DATA_W;

  logic [OP_W-1:0]  ex_op;
  logic [PRE_W-1:0] ex_pre1, ex_pre2;
  addr_t            ex_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_op   <= '0;
      ex_pre1 <= '0;
      ex_pre2 <= '0;
      ex_dest <= '0;
    end else begin
      ex_op   <= of_op;
      ex_pre1 <= of_pre1;
      ex_pre2 <= of_pre2;
      ex_dest <= of_dest;
    end
  end

  word_t   opnd_a, opnd_b;
  result_t add_now, mul_now, add_late, mul_late;
  logic    is_add, is_mul;

  assign opnd_a = pre_apply(ex_pre1, rd_a);
  assign opnd_b = pre_apply(ex_pre2, rd_b);
  assign is_add = (ex_op == OP_ADD);
  assign is_mul = (ex_op == OP_MUL);

  assign add_now = '{dest: ex_dest, data: fx_add(opnd_a, opnd_b)};
  assign mul_now = '{dest: ex_dest, data: fx_mul(opnd_a, opnd_b)};

  // results are computed at once and held back to the scheduled latency
  sc_delay_line #(.DEPTH(ADD_DEPTH), .WIDTH(RES_W)) u_add_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_v     (is_add),
    .in_data  (add_now),
    .out_v    (add_v),
    .out_data (add_late)
  );

  sc_delay_line #(.DEPTH(MUL_DEPTH), .WIDTH(RES_W)) u_mul_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_v     (is_mul),
    .in_data  (mul_now),
    .out_v    (mul_v),
    .out_data (mul_late)
  );

  assign add_dest = add_late.dest;
  assign add_data = add_late.data;
  assign mul_dest = mul_late.dest;
  assign mul_data = mul_late.data;

  assign out_we   = (ex_op == OP_OUT);
  assign out_idx  = ex_dest;
  assign out_data = opnd_a;
endmodule

// File: rtl/sc_retire.sv
module sc_retire
  import sc_core_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mul_v,
  input  addr_t                   mul_dest,
  input  word_t                   mul_data,
  input  logic                    add_v,
  input  addr_t                   add_dest,
  input  word_t                   add_data,
  input  logic                    in_v,
  input  addr_t                   in_dest,
  input  word_t                   in_data,
  input  logic                    out_we,
  input  addr_t                   out_idx,
  input  word_t                   out_data,
  output logic                    wr_en,
  output addr_t                   wr_addr,
  output word_t                   wr_data,
  output logic                    wr_clash,
  output logic [N_OUT*DATA_W-1:0] out_regs
);
  logic    clash_now;
  logic    win_v;
  result_t win;

  assign clash_now = ($countones({mul_v, add_v, in_v}) > 1);

  // one write port: the longest-latency result wins
  always_comb begin
    win_v = 1'b1;
    if (mul_v)      win = '{dest: mul_dest, data: mul_data};
    else if (add_v) win = '{dest: add_dest, data: add_data};
    else if (in_v)  win = '{dest: in_dest,  data: in_data};
    else begin
      win_v = 1'b0;
      win   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_clash <= 1'b0;
    end else begin
      wr_en    <= win_v;
      wr_addr  <= win.dest;
      wr_data  <= win.data;
      wr_clash <= clash_now;
    end
  end

  word_t out_q [N_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_OUT; k++) out_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_OUT; k++) begin
        if (out_we && out_idx == ADDR_W'(k)) out_q[k] <= out_data;
      end
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign out_regs[g*DATA_W +: DATA_W] = out_q[g];
  end

  a_r11_clash_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({mul_v, add_v, in_v}) > 1) |=> wr_clash);

  a_r9_write_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(mul_v || add_v || in_v));

  a_r4_in_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && !mul_v && !add_v) |=>
      (wr_en && wr_addr == $past(in_dest) && wr_data == $past(in_data)));

  a_r11_mul_wins: assert property (@(posedge clk) disable iff (!rst_n)
    mul_v |=> (wr_addr == $past(mul_dest) && wr_data == $past(mul_data)));
endmodule

// File: rtl/sched_core.sv
module sched_core
  import sc_core_pkg::*;
#(
  parameter int PC_W    = 6,
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int ADD_LAT = 5,
  parameter int MUL_LAT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [PC_W-1:0]         prog_addr,
  input  logic [INSTR_W-1:0]      prog_data,
  output logic [ADDR_W-1:0]       rd_addr_a,
  output logic [ADDR_W-1:0]       rd_addr_b,
  input  logic [DATA_W-1:0]       rd_data_a,
  input  logic [DATA_W-1:0]       rd_data_b,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    wr_clash,
  input  logic [N_IN*DATA_W-1:0]  in_regs,
  output logic [N_OUT*DATA_W-1:0] out_regs
);
  // named internal events between stages
  logic             in_v, add_v, mul_v, out_we;
  addr_t            in_dest, add_dest, mul_dest, out_idx;
  word_t            in_data, add_data, mul_data, out_data;
  logic [OP_W-1:0]  of_op;
  logic [PRE_W-1:0] of_pre1, of_pre2;
  addr_t            of_dest;

  sc_fetch_decode #(.PC_W(PC_W), .N_IN(N_IN)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .in_regs   (in_regs),
    .in_v      (in_v),
    .in_dest   (in_dest),
    .in_data   (in_data),
    .of_src1   (rd_addr_a),
    .of_src2   (rd_addr_b),
    .of_op     (of_op),
    .of_pre1   (of_pre1),
    .of_pre2   (of_pre2),
    .of_dest   (of_dest)
  );

  sc_execute #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .of_op    (of_op),
    .of_pre1  (of_pre1),
    .of_pre2  (of_pre2),
    .of_dest  (of_dest),
    .rd_a     (rd_data_a),
    .rd_b     (rd_data_b),
    .add_v    (add_v),
    .add_dest (add_dest),
    .add_data (add_data),
    .mul_v    (mul_v),
    .mul_dest (mul_dest),
    .mul_data (mul_data),
    .out_we   (out_we),
    .out_idx  (out_idx),
    .out_data (out_data)
  );

  sc_retire #(.N_OUT(N_OUT)) u_retire (
    .clk      (clk),
    .rst_n    (rst_n),
    .mul_v    (mul_v),
    .mul_dest (mul_dest),
    .mul_data (mul_data),
    .add_v    (add_v),
    .add_dest (add_dest),
    .add_data (add_data),
    .in_v     (in_v),
    .in_dest  (in_dest),
    .in_data  (in_data),
    .out_we   (out_we),
    .out_idx  (out_idx),
    .out_data (out_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_clash (wr_clash),
    .out_regs (out_regs)
  );
endmodule

// File: tb/sched_core_test.sv
`timescale 1ns/1ps
module sched_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  prog_addr;
  logic [24:0] prog_data;
  logic [5:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [15:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en, wr_clash;
  logic [63:0] in_regs;
  logic [63:0] out_regs;

  always #5 clk = ~clk;

  logic [24:0] prog [64];
  logic [15:0] mem  [64];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  assign prog_data = prog[prog_addr];

  // data memory model: one-cycle read, read returns the old word on a same-edge write
  always @(posedge clk) begin
    rd_data_a <= mem[rd_addr_a];
    rd_data_b <= mem[rd_addr_b];
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (wr_en) mem[wr_addr] <= wr_data;
  end

  sched_core uut (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_clash(wr_clash), .in_regs(in_regs), .out_regs(out_regs)
  );

  int checks = 0;
  int failures = 0;

  // per-cycle logs indexed by program counter
  logic        wl_v [64];
  logic [5:0]  wl_a [64];
  logic [15:0] wl_d [64];
  logic        cl_v [64];
  logic [5:0]  ra_l [64];
  logic [5:0]  rb_l [64];
  logic [15:0] o0_l [64];
  int          wr_cnt, clash_cnt;

  localparam logic [2:0] NOP = 3'd0, INP = 3'd1, OUTP = 3'd2, ADD = 3'd3, MUL = 3'd4;

  function automatic logic [24:0] mk(input logic [2:0] op, input logic [1:0] p1,
                                     input logic [1:0] p2, input logic [5:0] s1,
                                     input logic [5:0] s2, input logic [5:0] d);
    return {d, op, p2, p1, s2, s1};
  endfunction

  function automatic logic [15:0] b_pre(input logic [1:0] sel, input logic [15:0] v);
    if (sel == 2'd0) return v;
    if (sel == 2'd1) return 16'(0 - int'(v));
    if (sel == 2'd2) return (v >= 16'h8000) ? 16'(0 - int'(v)) : v;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] b_mul(input logic [15:0] a, input logic [15:0] b);
    longint pa, pb, pr;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = (pa * pb) >>> 8;
    return pr[15:0];
  endfunction

  function automatic logic [15:0] b_add(input logic [15:0] a, input logic [15:0] b);
    return 16'(int'(a) + int'(b));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic [5:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    in_regs = '0;
    for (int i = 0; i < 64; i++) prog[i] = '0;
    @(posedge clk); #1;
    for (int i = 0; i < 64; i++) load_word(6'(i), 16'h0000);
  endtask

  task automatic go(input int n);
    for (int i = 0; i < 64; i++) begin
      wl_v[i] = 1'b0; wl_a[i] = '0; wl_d[i] = '0; cl_v[i] = 1'b0;
      ra_l[i] = '0; rb_l[i] = '0; o0_l[i] = '0;
    end
    wr_cnt = 0; clash_cnt = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (wr_en) begin
        wr_cnt++;
        wl_v[prog_addr] = 1'b1; wl_a[prog_addr] = wr_addr; wl_d[prog_addr] = wr_data;
      end
      if (wr_clash) begin
        clash_cnt++;
        cl_v[prog_addr] = 1'b1;
      end
      ra_l[prog_addr] = rd_addr_a;
      rb_l[prog_addr] = rd_addr_b;
      o0_l[prog_addr] = out_regs[15:0];
    end
  endtask

  task automatic t_example();
    logic [15:0] x [4];
    logic [15:0] t1, t2, t3, t4;
    begin_test();
    x[0] = 16'h0180; x[1] = 16'hFF00; x[2] = 16'h0300; x[3] = 16'h0480;
    in_regs = {x[3], x[2], x[1], x[0]};
    load_word(6'h08, 16'h0200);
    load_word(6'h09, 16'h0080);
    load_word(6'h07, 16'h7777);
    prog[0]  = mk(INP, 0, 0, 6'd0, 6'd0, 6'h00);
    prog[1]  = mk(INP, 0, 0, 6'd1, 6'd0, 6'h01);
    prog[2]  = mk(MUL, 0, 0, 6'h00, 6'h08, 6'h04);
    prog[3]  = mk(MUL, 0, 0, 6'h01, 6'h09, 6'h05);
    prog[4]  = mk(INP, 0, 0, 6'd2, 6'd0, 6'h02);
    prog[5]  = mk(INP, 0, 0, 6'd3, 6'd0, 6'h03);
    prog[6]  = mk(ADD, 0, 0, 6'h00, 6'h01, 6'h06);
    prog[7]  = mk(ADD, 0, 1, 6'h02, 6'h03, 6'h07);
    prog[11] = mk(OUTP, 0, 0, 6'h07, 6'h00, 6'd0);
    prog[12] = mk(OUTP, 0, 0, 6'h07, 6'h00, 6'd1);
    go(24);
    t1 = b_mul(x[0], 16'h0200);
    t2 = b_mul(x[1], 16'h0080);
    t3 = b_add(x[0], x[1]);
    t4 = b_add(x[2], b_pre(2'd1, x[3]));
    for (int i = 0; i < 4; i++) chk(mem[i] == x[i], "R4 input copied to memory", mem[i], x[i]);
    chk(wl_v[2] && wl_a[2] == 6'h00, "R4 input write in cycle s+2", {wl_v[2], wl_a[2]}, {1'b1, 6'h00});
    chk(mem[4] == t1, "R6 multiply t1", mem[4], t1);
    chk(mem[5] == t2, "R6 multiply t2 negative", mem[5], t2);
    chk(wl_v[9] && wl_a[9] == 6'h04 && !wl_v[8], "R6 multiply write in cycle s+7", {wl_v[8], wl_v[9], wl_a[9]}, {1'b0, 1'b1, 6'h04});
    chk(mem[6] == t3, "R5 add t3", mem[6], t3);
    chk(wl_v[12] && wl_a[12] == 6'h06, "R5 add write in cycle s+6", {wl_v[12], wl_a[12]}, {1'b1, 6'h06});
    chk(mem[7] == t4, "R7 subtract via negate", mem[7], t4);
    chk(wl_v[13] && wl_a[13] == 6'h07, "R13 last write in cycle 13", {wl_v[13], wl_a[13]}, {1'b1, 6'h07});
    chk(ra_l[4] == 6'h00 && rb_l[4] == 6'h08, "R3 read addresses in cycle s+2", {ra_l[4], rb_l[4]}, {6'h00, 6'h08});
    chk(out_regs[15:0] == 16'h7777, "R5 slot s+4 reads old value", out_regs[15:0], 16'h7777);
    chk(out_regs[31:16] == t4, "R13 slot 12 reads final result", out_regs[31:16], t4);
    chk(o0_l[14] == 16'h0000 && o0_l[15] == 16'h7777, "R10 output visible from s+4", {o0_l[14], o0_l[15]}, {16'h0000, 16'h7777});
    chk(wr_cnt == 8, "R9 only eight writes, none from no-op or output", wr_cnt, 8);
    chk(clash_cnt == 0, "R11 no clash in clean schedule", clash_cnt, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(prog_addr == 6'd0, "R12 pc zero in reset", prog_addr, 0);
    chk(!wr_en && !wr_clash, "R12 no write or clash in reset", {wr_en, wr_clash}, 0);
    chk(out_regs == 64'd0, "R12 output registers cleared", out_regs[31:0], 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(prog_addr == 6'(c + 1) || c == 0 && prog_addr == 6'd0 || prog_addr == 6'(c),
          "R1 pc advances", prog_addr, c);
    end
    chk(prog_addr == 6'd4, "R1 pc reaches 4 after four edges", prog_addr, 4);
  endtask

  task automatic t_preops();
    logic [15:0] m10, m11, m12, m13;
    begin_test();
    m10 = 16'hFD40; m11 = 16'hFE00; m12 = 16'h7FFF; m13 = 16'h0001;
    load_word(6'd10, m10); load_word(6'd11, m11);
    load_word(6'd12, m12); load_word(6'd13, m13);
    load_word(6'd23, 16'h1111); load_word(6'd24, 16'h2222);
    prog[0] = mk(ADD, 3, 0, 6'd10, 6'd11, 6'd21);
    prog[1] = mk(ADD, 2, 1, 6'd10, 6'd11, 6'd22);
    prog[2] = mk(ADD, 0, 0, 6'd12, 6'd13, 6'd25);
    prog[3] = mk(3'd5, 0, 0, 6'd10, 6'd11, 6'd23);
    prog[4] = mk(NOP, 1, 1, 6'd10, 6'd11, 6'd24);
    prog[5] = mk(OUTP, 1, 0, 6'd10, 6'd0, 6'd2);
    prog[6] = mk(MUL, 1, 2, 6'd10, 6'd11, 6'd20);
    prog[7] = mk(MUL, 0, 0, 6'd12, 6'd12, 6'd26);
    go(24);
    chk(mem[21] == b_add(16'h0, m11), "R7 zero pre-operation", mem[21], b_add(16'h0, m11));
    chk(mem[22] == b_add(b_pre(2, m10), b_pre(1, m11)), "R7 abs and negate", mem[22], b_add(b_pre(2, m10), b_pre(1, m11)));
    chk(mem[25] == b_add(m12, m13), "R5 add wraps modulo 2^16", mem[25], b_add(m12, m13));
    chk(mem[20] == b_mul(b_pre(1, m10), b_pre(2, m11)), "R6 multiply with pre-operations", mem[20], b_mul(b_pre(1, m10), b_pre(2, m11)));
    chk(mem[26] == b_mul(m12, m12), "R6 multiply truncation", mem[26], b_mul(m12, m12));
    chk(mem[23] == 16'h1111, "R2 reserved opcode writes nothing", mem[23], 16'h1111);
    chk(mem[24] == 16'h2222, "R9 no-op writes nothing", mem[24], 16'h2222);
    chk(wr_cnt == 5, "R9 write count", wr_cnt, 5);
    chk(out_regs[47:32] == b_pre(1, m10), "R10 output with negate", out_regs[47:32], b_pre(1, m10));
  endtask

  task automatic t_clash();
    logic [15:0] m10, m11;
    begin_test();
    m10 = 16'h0240; m11 = 16'hFF40;
    in_regs = {16'h0, 16'h0, 16'h0BAD, 16'h0ACE};
    load_word(6'd10, m10); load_word(6'd11, m11);
    load_word(6'd31, 16'h5A5A); load_word(6'd34, 16'hA5A5);
    prog[0]  = mk(MUL, 0, 0, 6'd10, 6'd11, 6'd30);
    prog[1]  = mk(ADD, 0, 0, 6'd10, 6'd11, 6'd31);
    prog[6]  = mk(ADD, 0, 0, 6'd10, 6'd11, 6'd33);
    prog[10] = mk(INP, 0, 0, 6'd1, 6'd0, 6'd34);
    go(24);
    chk(cl_v[7] && cl_v[12], "R11 clash flagged in both write cycles", {cl_v[7], cl_v[12]}, 2'b11);
    chk(clash_cnt == 2, "R11 clash only in collision cycles", clash_cnt, 2);
    chk(wl_a[7] == 6'd30 && wl_d[7] == b_mul(m10, m11), "R11 multiply wins", {wl_a[7], wl_d[7]}, {6'd30, b_mul(m10, m11)});
    chk(mem[31] == 16'h5A5A, "R11 losing add not written", mem[31], 16'h5A5A);
    chk(mem[33] == b_add(m10, m11), "R11 add beats input", mem[33], b_add(m10, m11));
    chk(mem[34] == 16'hA5A5, "R11 losing input not written", mem[34], 16'hA5A5);
  endtask

  task automatic t_stream();
    logic [15:0] v;
    begin_test();
    for (int i = 0; i < 8; i++) load_word(6'(50 + i), 16'(16'h0100 * (i + 1) - 3 * i));
    for (int i = 0; i < 8; i++) prog[i] = mk(ADD, 0, 0, 6'(50 + i), 6'(50 + i), 6'(40 + i));
    go(24);
    chk(wr_cnt == 8, "R8 one write per issued add", wr_cnt, 8);
    for (int i = 0; i < 8; i++) begin
      v = 16'(16'h0100 * (i + 1) - 3 * i);
      chk(wl_v[6 + i] && wl_a[6 + i] == 6'(40 + i), "R8 back-to-back write cycle", {wl_v[6 + i], wl_a[6 + i]}, {1'b1, 6'(40 + i)});
      chk(mem[40 + i] == b_add(v, v), "R8 back-to-back result", mem[40 + i], b_add(v, v));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    in_regs = '0;
    t_example();
    t_reset();
    t_preops();
    t_clash();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule